// File: doc/BRIEF.md
# Local-Bus Interrupt Source Controller

This block collects level interrupt requests from up to sixteen local-bus devices and presents them to a processor as one combined interrupt line. Each device line is sampled into a pending word. A software-written enable mask chooses which pending lines may raise the combined output. The lines that are both pending and enabled form the active set.

A read-only source register reports which active line to service first. It returns a vector for the lowest-numbered active line, or zero when no line is active. The two registers are natively 16 bits wide. They sit behind a single-cycle bus port that accepts byte, halfword and word accesses. A byte write does a read-merge-write on the halfword that holds it. A word access is split into two halfword accesses at the given address and at that address plus two.

Top module: `lbus_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pending word and the enable mask are zero, `irq_o` is low, and reads at offsets 0x000 and 0x002 return zero.
- R2: Each pending bit takes the level of its `dev_irq` bit at every clock edge. `irq_o` is high exactly when (pending AND mask) is non-zero, one cycle after the input level is sampled.
- R3: A halfword read at offset 0x000 returns 0 when no line is active. Otherwise it returns (n+1) shifted left by 2, where n is the lowest-numbered line that is both pending and enabled.
- R4: A halfword at offset 0x002 is the enable mask. A write stores it, and reads return the stored value. `irq_o` reflects the new mask in the cycle right after the write edge.
- R5: The `bus_size` encoding is 2'b00 byte, 2'b01 halfword, 2'b10 word. The code 2'b11 is reserved: a read with it returns zero, and a write with it changes nothing.
- R6: A byte read returns, in `bus_rdata[7:0]`, the low byte (address bit 0 = 0) or the high byte (bit 0 = 1) of the halfword register at the address with bit 0 cleared. Bits 31:8 are zero.
- R7: A byte write takes `bus_wdata[7:0]` and replaces only the addressed byte lane of the halfword at the address with bit 0 cleared: bits 7:0 for an even address, bits 15:8 for an odd one. The other lane keeps its value.
- R8: A word access acts as two halfword accesses. `bus_rdata[15:0]` and `bus_wdata[15:0]` go to the given offset. `bus_rdata[31:16]` and `bus_wdata[31:16]` go to that offset plus 2, with the sum wrapping in 12 bits.
- R9: A halfword access at any offset other than 0x000 or 0x002, including odd offsets, reads zero and is ignored when written. Offset 0x000 cannot be written.
- R10: Only address bits 11:0 are decoded. Bits above them have no effect on reads or writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_irq | input | NUM_LINES (16) | Level requests from the devices, bit n = line n |
| bus_addr | input | ADDR_W (32) | Byte address of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| bus_wdata | input | 32 | Write data, with the lanes set by size and R8 |
| bus_rdata | output | 32 | Combinational read data for the presented address and size |
| irq_o | output | 1 | Combined interrupt, high while any enabled line is pending |

## Verification
The hardest case to reach from the ports is the priority choice among several lines that are pending and enabled at once. It needs a mask and an input pattern that both have several bits set. Only the lowest common bit may show in the vector, and a stale pending bit from the previous cycle must not leak in. The bench drives random level patterns together with random masks that were themselves built from mixed byte, halfword and word writes. It then reads the source register through all three access sizes, including word reads that place the vector in the low half and the mask in the high half. Directed walks over single lines and the 0xFFE wrap cover the boundaries.

// File: rtl/lbic_pkg.sv
// Shared definitions for the local-bus interrupt source controller.
// Assumes a natively 16-bit register window decoded on 12 address bits.
package lbic_pkg;

    localparam int REG_W  = 16;
    localparam int DEC_W  = 12;
    localparam int BUS_W  = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam logic [DEC_W-1:0] OFF_SRC  = 12'h000;
    localparam logic [DEC_W-1:0] OFF_MASK = 12'h002;

endpackage

// File: rtl/lbic_pending.sv
// Pending-status capture: one flop per device line, following the input level.
// Assumes device lines are synchronous to clk (level requests, no edge logic).
module lbic_pending #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_i,
    output logic [NUM_LINES-1:0] pend_o
);

    // Sample every line's level into its pending bit each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= lines_i;
    end

    // R2
    pend_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> pend_o == $past(lines_i));

endmodule

// File: rtl/lbic_prio_enc.sv
// Lowest-first priority encoder producing the source vector (n+1)<<2.
// Assumes NUM_LINES is small enough that (NUM_LINES)<<2 fits in REG_W bits.
module lbic_prio_enc
    import lbic_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic [NUM_LINES-1:0] act_i,
    output logic [REG_W-1:0]     vec_o
);

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES:0]   below;
    logic [NUM_LINES-1:0] first;
    logic [IDX_W-1:0]     idx;

    assign below[0] = 1'b0;

    // Prefix chain: first[i] is set only for the lowest active line.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chain
        assign below[i+1] = below[i] | act_i[i];
        assign first[i]   = act_i[i] & ~below[i];
    end

    // Convert the one-hot winner to a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (first[i]) idx = idx | IDX_W'(i);
        end
    end

    // Form the vector, zero when nothing is active.
    always_comb begin
        if (below[NUM_LINES]) vec_o = REG_W'((32'(idx) + 32'd1) << 2);
        else                  vec_o = '0;
    end

    // R3
    winner_onehot_chk: assert final ($onehot0(first));
    // R3
    vec_zero_iff_idle_chk: assert final ((vec_o == '0) == (act_i == '0));

endmodule

// File: rtl/lbic_bus_if.sv
// Byte-lane adapter: maps 8/16/32-bit accesses onto the 16-bit register pair.
// Byte writes merge into the aligned halfword; words split at addr and addr+2.
// Assumes a single-cycle bus, read data combinational from the address.
module lbic_bus_if
    import lbic_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [1:0]        size_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [REG_W-1:0]  vec_i,
    input  logic [REG_W-1:0]  mask_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              mask_we_o,
    output logic [REG_W-1:0]  mask_nxt_o
);

    logic [DEC_W-1:0] off;
    logic [DEC_W-1:0] off_al;
    logic [DEC_W-1:0] off_hi;
    logic [REG_W-1:0] h_al;
    logic [REG_W-1:0] h_lo;
    logic [REG_W-1:0] h_hi;

    // Halfword register read for one decoded offset.
    function automatic logic [REG_W-1:0] half_rd(input logic [DEC_W-1:0] o,
                                                 input logic [REG_W-1:0] v,
                                                 input logic [REG_W-1:0] m);
        if (o == OFF_SRC)       return v;
        else if (o == OFF_MASK) return m;
        else                    return '0;
    endfunction

    assign off    = addr_i[DEC_W-1:0];
    assign off_al = {off[DEC_W-1:1], 1'b0};
    assign off_hi = off + DEC_W'(2);

    // Fetch the halfwords that any access size may need.
    always_comb begin
        h_al = half_rd(off_al, vec_i, mask_i);
        h_lo = half_rd(off,    vec_i, mask_i);
        h_hi = half_rd(off_hi, vec_i, mask_i);
    end

    // Read data mux by access size.
    always_comb begin
        case (acc_size_e'(size_i))
            SZ_BYTE: rdata_o = {24'd0, off[0] ? h_al[15:8] : h_al[7:0]};
            SZ_HALF: rdata_o = {16'd0, h_lo};
            SZ_WORD: rdata_o = {h_hi, h_lo};
            default: rdata_o = '0;
        endcase
    end

    // Write steering to the mask, with byte-lane merge.
    always_comb begin
        mask_we_o  = 1'b0;
        mask_nxt_o = mask_i;
        if (we_i) begin
            case (acc_size_e'(size_i))
                SZ_BYTE: if (off_al == OFF_MASK) begin
                    mask_we_o  = 1'b1;
                    mask_nxt_o = off[0] ? {wdata_i[7:0], mask_i[7:0]}
                                        : {mask_i[15:8], wdata_i[7:0]};
                end
                SZ_HALF: if (off == OFF_MASK) begin
                    mask_we_o  = 1'b1;
                    mask_nxt_o = wdata_i[15:0];
                end
                SZ_WORD: begin
                    if (off == OFF_MASK) begin
                        mask_we_o  = 1'b1;
                        mask_nxt_o = wdata_i[15:0];
                    end else if (off_hi == OFF_MASK) begin
                        mask_we_o  = 1'b1;
                        mask_nxt_o = wdata_i[31:16];
                    end
                end
                default: ;
            endcase
        end
    end

    // R5
    rsvd_no_read_chk: assert final (size_i != 2'b11 || rdata_o == '0);
    // R6
    byte_upper_zero_chk: assert final (size_i != 2'b00 || rdata_o[31:8] == '0);

endmodule

// File: rtl/lbus_irq_ctrl.sv
// Top of the local-bus interrupt source controller: pending capture, enable
// mask, lowest-first vector encode and byte-lane bus access.
// Assumes synchronous active-low reset and level device requests.
module lbus_irq_ctrl
    import lbic_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] dev_irq,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [1:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq_o
);

    logic [NUM_LINES-1:0] pend;
    logic [REG_W-1:0]     mask_q;
    logic [REG_W-1:0]     mask_nxt;
    logic                 mask_we;
    logic [NUM_LINES-1:0] act;
    logic [REG_W-1:0]     vec;

    lbic_pending #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (dev_irq),
        .pend_o  (pend)
    );

    assign act = pend & mask_q[NUM_LINES-1:0];

    lbic_prio_enc #(.NUM_LINES(NUM_LINES)) u_enc (
        .act_i (act),
        .vec_o (vec)
    );

    lbic_bus_if #(.ADDR_W(ADDR_W)) u_bus (
        .addr_i     (bus_addr),
        .we_i       (bus_we),
        .size_i     (bus_size),
        .wdata_i    (bus_wdata),
        .vec_i      (vec),
        .mask_i     (mask_q),
        .rdata_o    (bus_rdata),
        .mask_we_o  (mask_we),
        .mask_nxt_o (mask_nxt)
    );

    // Enable-mask register, loaded from the bus adapter.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_nxt;
    end

    // Combined interrupt from the active set.
    assign irq_o = |act;

    // R4
    half_mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_size == 2'b01 && bus_addr[DEC_W-1:0] == OFF_MASK
        |=> mask_q == $past(bus_wdata[15:0]));
    // R9
    no_wr_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(mask_q));
    // R5
    rsvd_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_size == 2'b11 |=> $stable(mask_q));
    // R7
    byte_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_size == 2'b00 && bus_addr[DEC_W-1:0] == 12'h002
        |=> mask_q[15:8] == $past(mask_q[15:8]) && mask_q[7:0] == $past(bus_wdata[7:0]));
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !irq_o && mask_q == '0);

endmodule

// File: tb/lbus_irq_ctrl_tb.sv
module lbus_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dev_irq = '0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'b01;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    logic [15:0] m_mask = '0;
    logic [15:0] m_pend = '0;

    always #5 clk = ~clk;

    lbus_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [15:0] m_vec();
        logic [15:0] a = m_pend & m_mask;
        for (int i = 0; i < 16; i++)
            if (a[i]) return 16'((i + 1) * 4);
        return 16'h0;
    endfunction

    function automatic logic [15:0] m_half(input logic [11:0] o);
        if (o == 12'h000) return m_vec();
        if (o == 12'h002) return m_mask;
        return 16'h0;
    endfunction

    function automatic logic [31:0] m_read(input logic [31:0] a, input logic [1:0] sz);
        logic [11:0] o = a[11:0];
        logic [15:0] h;
        case (sz)
            2'b00: begin
                h = m_half({o[11:1], 1'b0});
                return {24'h0, o[0] ? h[15:8] : h[7:0]};
            end
            2'b01: return {16'h0, m_half(o)};
            2'b10: return {m_half(o + 12'd2), m_half(o)};
            default: return 32'h0;
        endcase
    endfunction

    function automatic void m_halfwr(input logic [11:0] o, input logic [15:0] v);
        if (o == 12'h002) m_mask = v;
    endfunction

    function automatic void m_write(input logic [31:0] a, input logic [1:0] sz,
                                    input logic [31:0] d);
        logic [11:0] o = a[11:0];
        logic [15:0] h;
        case (sz)
            2'b00: begin
                h = m_half({o[11:1], 1'b0});
                if (o[0]) h[15:8] = d[7:0]; else h[7:0] = d[7:0];
                m_halfwr({o[11:1], 1'b0}, h);
            end
            2'b01: m_halfwr(o, d[15:0]);
            2'b10: begin
                m_halfwr(o, d[15:0]);
                m_halfwr(o + 12'd2, d[31:16]);
            end
            default: ;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check reads and irq, update model at edge.
    task automatic cyc(input logic we, input logic [31:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input logic [15:0] lines, input string tag);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d; dev_irq = lines;
        #1;
        check({tag, " irq R2"}, {31'd0, irq_o}, {31'd0, |(m_pend & m_mask)});
        if (!we) check({tag, " rdata"}, bus_rdata, m_read(a, sz));
        @(posedge clk);
        if (we) m_write(a, sz, d);
        m_pend = lines;
    endtask

    function automatic logic [31:0] pick_addr();
        logic [11:0] lo;
        case ($urandom_range(0, 7))
            0: lo = 12'h000; 1: lo = 12'h001; 2: lo = 12'h002; 3: lo = 12'h003;
            4: lo = 12'h004; 5: lo = 12'hffe; 6: lo = 12'hfff;
            default: lo = 12'($urandom_range(0, 4095));
        endcase
        return {($urandom_range(0, 1) != 0) ? 20'($urandom) : 20'h0, lo};
    endfunction

    initial begin : watchdog
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1c0ffee));
        dev_irq = 16'hffff;
        repeat (3) @(posedge clk);
        // R1 reset state, dev lines high while in reset
        @(negedge clk);
        check("R1 irq in reset", {31'd0, irq_o}, 32'd0);
        bus_size = 2'b10; bus_addr = 32'h0; #1;
        check("R1 word read zero", bus_rdata, 32'h0);
        rst_n = 1'b1; dev_irq = '0;
        @(posedge clk);

        // R4 mask write and readback
        cyc(1, 32'h2, 2'b01, 32'h0000_a5c3, 16'h0000, "R4 wr");
        cyc(0, 32'h2, 2'b01, 32'h0, 16'h0000, "R4 readback");
        // R2/R3 each single line with full mask
        cyc(1, 32'h2, 2'b01, 32'h0000_ffff, 16'h0000, "R4 full");
        for (int i = 0; i < 16; i++) begin
            cyc(0, 32'h0, 2'b01, 32'h0, 16'(1 << i), "R3 single");
            cyc(0, 32'h0, 2'b01, 32'h0, 16'(1 << i), "R3 single vec");
        end
        // R3 several active: lowest wins
        cyc(0, 32'h0, 2'b01, 32'h0, 16'hf0a0, "R3 multi");
        cyc(0, 32'h0, 2'b01, 32'h0, 16'hf0a0, "R3 multi vec");
        // R4 mask removes pending line, irq drops after write edge
        cyc(1, 32'h2, 2'b01, 32'h0000_0f00, 16'hf0a0, "R4 mask off");
        cyc(0, 32'h0, 2'b01, 32'h0, 16'hf0a0, "R4 irq low");
        // R7 byte writes to each lane
        cyc(1, 32'h3, 2'b00, 32'h0000_0081, 16'h0000, "R7 hi lane");
        cyc(1, 32'h2, 2'b00, 32'h0000_0042, 16'h0000, "R7 lo lane");
        cyc(0, 32'h2, 2'b01, 32'h0, 16'h0000, "R7 merge");
        // R6 byte reads
        cyc(0, 32'h3, 2'b00, 32'h0, 16'h0000, "R6 hi byte");
        cyc(0, 32'h2, 2'b00, 32'h0, 16'h0000, "R6 lo byte");
        // R8 word read at 0 and wrap at 0xffe
        cyc(0, 32'h0, 2'b10, 32'h0, 16'h0002, "R8 word0");
        cyc(0, 32'hffe, 2'b10, 32'h0, 16'h0002, "R8 wrap");
        cyc(1, 32'h0, 2'b10, 32'h1234_ffff, 16'h0002, "R8 word wr hi");
        cyc(0, 32'h2, 2'b01, 32'h0, 16'h0002, "R8 mask from hi");
        // R5 reserved size
        cyc(1, 32'h2, 2'b11, 32'hffff_ffff, 16'h0000, "R5 rsvd wr");
        cyc(0, 32'h2, 2'b11, 32'h0, 16'h0000, "R5 rsvd rd");
        cyc(0, 32'h2, 2'b01, 32'h0, 16'h0000, "R5 mask kept");
        // R9 other offsets and odd halfword
        cyc(1, 32'h4, 2'b01, 32'h0000_ffff, 16'h0000, "R9 off4 wr");
        cyc(1, 32'h3, 2'b01, 32'h0000_ffff, 16'h0000, "R9 odd wr");
        cyc(1, 32'h0, 2'b01, 32'h0000_ffff, 16'h0000, "R9 src wr");
        cyc(0, 32'h2, 2'b01, 32'h0, 16'h0000, "R9 mask kept");
        // R10 high address bits ignored
        cyc(1, 32'hdead_b002, 2'b01, 32'h0000_00ff, 16'h0010, "R10 hi wr");
        cyc(0, 32'h8000_0002, 2'b01, 32'h0, 16'h0010, "R10 hi rd");
        cyc(0, 32'h7770_0000, 2'b01, 32'h0, 16'h0010, "R10 vec");

        // random mix, R2 R3 R6 R7 R8
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] sz = 2'($urandom_range(0, 3));
            logic we = ($urandom_range(0, 2) == 0);
            cyc(we, pick_addr(), sz, $urandom, 16'($urandom & $urandom), "RND R2 R3");
        end

        // R1 reset again clears mask and pending
        @(negedge clk); rst_n = 1'b0; dev_irq = 16'hffff;
        @(posedge clk); m_mask = '0; m_pend = '0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        bus_size = 2'b01; bus_addr = 32'h2; bus_we = 1'b0; #1;
        check("R1 mask after reset", bus_rdata, 32'h0);
        @(posedge clk); m_pend = 16'hffff;
        cyc(0, 32'h0, 2'b10, 32'h0, 16'h0, "R1 word after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule